// File: doc/BRIEF.md
# Multi-Depth Pixel Serializer

This block takes a display byte that a fetch unit has already read and turns it into one pixel colour per clock. A byte holds eight pixels of one bit, four of two bits or two of four bits. A pixel of more than one bit is not a contiguous field. Its bits are interleaved across the byte at a fixed stride. Each logical pixel is repeated for one, two or four clocks to stretch a narrow mode across the full line. The logical colour is then taken modulo 8, passed through an eight-entry palette and driven as registered red, green and blue levels.

The surrounding display pipeline supplies four things. The first is a pixel-window flag that is high across the visible span of a line. The second is a flag that marks blank spacing lines between character rows. The other two are the depth and scale codes for the current mode. The block has a small state machine with two states. In `SER_IDLE` the output is black, and the machine waits for the window. The transition *start* moves it to `SER_RUN` and loads the byte. In `SER_RUN`, pixels are stepped through. The transition *step* advances the index after the scale count runs out. The transition *reload* samples a new byte when the last pixel of the current byte has been shown. The transition *stop* returns to `SER_IDLE` when the window closes or a blank line begins.

Top module: `pix_serializer`

## Requirements
- R1: With `depth_sel` = 0, the eight pixels of a byte are shown from bit 7 down to bit 0.
- R2: With `depth_sel` = 1, pixel k (k = 0..3) has bit (7-k) of the byte as its upper bit and bit (3-k) as its lower bit.
- R3: With `depth_sel` = 2, pixel 0 is formed from bits 7, 5, 3 and 1 and pixel 1 from bits 6, 4, 2 and 0, each listed most significant first. The resulting 4-bit colour is reduced modulo 8 before the palette lookup.
- R4: `depth_sel` = 3 behaves exactly like `depth_sel` = 0.
- R5: Each logical pixel is held for 1, 2 or 4 clocks when `scale_sel` is 0, 1 or 2 respectively. `scale_sel` = 3 holds for 1 clock.
- R6: `byte_in` is sampled on the first clock of the window, and again on the clock that follows the last pixel of the current byte. A value on `byte_in` at any other clock has no effect on the output.
- R7: The palette maps the logical colour to a 3-bit physical colour. Bit 0 of that colour drives `red_o`, bit 1 drives `green_o` and bit 2 drives `blue_o`. The default palette is the identity map.
- R8: On any clock where `pix_active` is low or `blank_line` is high, the output is black. When the window is entered again, the sequence restarts at pixel 0 of a newly sampled byte.
- R9: The output is registered. The colour for the inputs seen at a rising edge appears just after that edge. The output is black while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_in | input | 8 | Display byte from the fetch unit |
| depth_sel | input | 2 | 0: 1 bpp, 1: 2 bpp, 2: 4 bpp, 3: 1 bpp |
| scale_sel | input | 2 | 0: x1, 1: x2, 2: x4, 3: x1 |
| pix_active | input | 1 | High inside the pixel window |
| blank_line | input | 1 | High on blank spacing lines |
| red_o | output | 1 | Red level, registered |
| green_o | output | 1 | Green level, registered |
| blue_o | output | 1 | Blue level, registered |

## Verification
The hardest situation to reach from the ports is proving that `byte_in` is ignored between reloads. A well-behaved fetch unit holds the byte steady, and that would hide a serializer that samples on every clock. The stimulus therefore places the real byte on `byte_in` only on the reload clocks, and drives the inverse of that byte on every other clock. Any premature sample then shows up as a wrong colour. A second hard case is a blank line that starts part way through a byte. Stimulus raises `blank_line` in the middle of a run, then lowers it with a different byte present, and checks that the run restarts at pixel 0.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;

    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_RUN  = 1'b1
    } ser_state_t;

    localparam int BYTE_W  = 8;
    localparam int IDX_W   = 3;
    localparam int CNT_W   = 2;
    localparam int COL_W   = 3;
    localparam int PAL_N   = 8;

    // Index of the last pixel in a byte for a depth code.
    function automatic logic [IDX_W-1:0] last_index(input logic [1:0] depth_code);
        case (depth_code)
            2'd1:    return IDX_W'(3);
            2'd2:    return IDX_W'(1);
            default: return IDX_W'(7);
        endcase
    endfunction

    // Reload value of the hold counter for a scale code.
    function automatic logic [CNT_W-1:0] hold_reload(input logic [1:0] scale_code);
        case (scale_code)
            2'd1:    return CNT_W'(1);
            2'd2:    return CNT_W'(3);
            default: return CNT_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/pix_decode.sv
module pix_decode
    import pix_ser_pkg::*;
(
    input  logic [BYTE_W-1:0] data,
    input  logic [1:0]        depth_code,
    input  logic [IDX_W-1:0]  idx,
    output logic [COL_W-1:0]  colour
);

    logic [1:0] k2;
    logic       k1;

    assign k2 = idx[1:0];
    assign k1 = idx[0];

    always_comb begin
        colour = '0;
        unique case (depth_code)
            2'd1: begin
                // Upper bit from the high nibble, lower bit from the low nibble.
                colour = {1'b0, data[3'd7 - {1'b0, k2}], data[3'd3 - {1'b0, k2}]};
            end
            2'd2: begin
                // Stride-two interleave; bit 3 of the colour drops (modulo 8).
                colour = {data[3'd5 - {2'b0, k1}],
                          data[3'd3 - {2'b0, k1}],
                          data[3'd1 - {2'b0, k1}]};
            end
            default: begin
                colour = {2'b0, data[3'd7 - idx]};
            end
        endcase
    end

endmodule

// File: rtl/pix_palette.sv
module pix_palette
    import pix_ser_pkg::*;
#(
    parameter logic [PAL_N*COL_W-1:0] PALETTE = {3'd7, 3'd6, 3'd5, 3'd4,
                                                 3'd3, 3'd2, 3'd1, 3'd0}
) (
    input  logic [COL_W-1:0] logical,
    output logic [COL_W-1:0] physical
);

    logic [COL_W-1:0] entry [PAL_N];

    for (genvar g = 0; g < PAL_N; g++) begin : g_entry
        assign entry[g] = PALETTE[g*COL_W +: COL_W];
    end

    assign physical = entry[logical];

endmodule

// File: rtl/pix_seq.sv
module pix_seq
    import pix_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              show,
    input  logic [1:0]        depth_code,
    input  logic [1:0]        scale_code,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] cur_byte,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              run,
    output logic [IDX_W-1:0]  idx_q_o,
    output logic [CNT_W-1:0]  cnt_q_o
);

    ser_state_t        state_q, state_n;
    logic [IDX_W-1:0]  idx_q, idx_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [BYTE_W-1:0] buf_q;
    logic              load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SER_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            buf_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            cnt_q   <= cnt_n;
            if (load) buf_q <= byte_in;
        end
    end

    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        cnt_n   = cnt_q;
        load    = 1'b0;
        unique case (state_q)
            SER_IDLE: begin
                if (show) begin
                    state_n = SER_RUN;
                    load    = 1'b1;
                    idx_n   = '0;
                    cnt_n   = hold_reload(scale_code);
                end
            end
            SER_RUN: begin
                if (!show) begin
                    state_n = SER_IDLE;
                end else if (cnt_q == '0) begin
                    cnt_n = hold_reload(scale_code);
                    if (idx_q >= last_index(depth_code)) begin
                        load  = 1'b1;
                        idx_n = '0;
                    end else begin
                        idx_n = idx_q + 1'b1;
                    end
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
        endcase
    end

    assign cur_byte = load ? byte_in : buf_q;
    assign cur_idx  = idx_n;
    assign run      = (state_q == SER_RUN);
    assign idx_q_o  = idx_q;
    assign cnt_q_o  = cnt_q;

endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
    import pix_ser_pkg::*;
#(
    parameter logic [PAL_N*COL_W-1:0] PALETTE = {3'd7, 3'd6, 3'd5, 3'd4,
                                                 3'd3, 3'd2, 3'd1, 3'd0}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] byte_in,
    input  logic [1:0] depth_sel,
    input  logic [1:0] scale_sel,
    input  logic       pix_active,
    input  logic       blank_line,
    output logic       red_o,
    output logic       green_o,
    output logic       blue_o
);

    logic              show;
    logic [BYTE_W-1:0] cur_byte;
    logic [IDX_W-1:0]  cur_idx;
    logic              seq_run;
    logic [IDX_W-1:0]  seq_idx;
    logic [CNT_W-1:0]  seq_cnt;
    logic [COL_W-1:0]  logical;
    logic [COL_W-1:0]  physical;
    logic [COL_W-1:0]  rgb_q;

    assign show = pix_active && !blank_line;

    pix_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .show       (show),
        .depth_code (depth_sel),
        .scale_code (scale_sel),
        .byte_in    (byte_in),
        .cur_byte   (cur_byte),
        .cur_idx    (cur_idx),
        .run        (seq_run),
        .idx_q_o    (seq_idx),
        .cnt_q_o    (seq_cnt)
    );

    pix_decode u_dec (
        .data       (cur_byte),
        .depth_code (depth_sel),
        .idx        (cur_idx),
        .colour     (logical)
    );

    pix_palette #(.PALETTE(PALETTE)) u_pal (
        .logical  (logical),
        .physical (physical)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rgb_q <= '0;
        else if (show) rgb_q <= physical;
        else           rgb_q <= '0;
    end

    assign red_o   = rgb_q[0];
    assign green_o = rgb_q[1];
    assign blue_o  = rgb_q[2];

endmodule

// File: rtl/pix_serializer_chk.sv
module pix_serializer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pix_active,
    input logic       blank_line,
    input logic [1:0] depth_sel,
    input logic       red_o,
    input logic       green_o,
    input logic       blue_o,
    input logic       run,
    input logic [2:0] idx,
    input logic [1:0] cnt
);

    logic       vis;
    logic [2:0] last;

    assign vis  = pix_active && !blank_line;
    assign last = (depth_sel == 2'd1) ? 3'd3 : (depth_sel == 2'd2) ? 3'd1 : 3'd7;

    // R8: black on the clock after any non-visible input
    a_r8_black: assert property (@(posedge clk) disable iff (!rst_n)
        !vis |=> ({blue_o, green_o, red_o} == 3'b000));

    // R5: a pixel index does not move while its hold count is running
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != 2'd0) |=> $stable(idx));

    // R6: entering the window starts at pixel 0
    a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && vis) |=> (run && idx == 3'd0));

    // R6: after the last pixel of a byte the index wraps to 0
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run && vis && cnt == 2'd0 && idx == last) |=> (idx == 3'd0));

endmodule

bind pix_serializer pix_serializer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_active (pix_active),
    .blank_line (blank_line),
    .depth_sel  (depth_sel),
    .red_o      (red_o),
    .green_o    (green_o),
    .blue_o     (blue_o),
    .run        (seq_run),
    .idx        (seq_idx),
    .cnt        (seq_cnt)
);

// File: tb/pix_serializer_tb.sv
module pix_serializer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic [1:0] depth_sel = 2'd0;
    logic [1:0] scale_sel = 2'd0;
    logic       pix_active = 1'b0;
    logic       blank_line = 1'b0;
    logic       red_o, green_o, blue_o;

    int applied = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pix_serializer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_in    (byte_in),
        .depth_sel  (depth_sel),
        .scale_sel  (scale_sel),
        .pix_active (pix_active),
        .blank_line (blank_line),
        .red_o      (red_o),
        .green_o    (green_o),
        .blue_o     (blue_o)
    );

    // {depth, scale, byte0, byte1}
    localparam logic [19:0] VEC [9] = '{
        {2'd0, 2'd0, 8'hA5, 8'h3C},
        {2'd0, 2'd1, 8'hF0, 8'h81},
        {2'd1, 2'd0, 8'hB4, 8'h1E},
        {2'd1, 2'd2, 8'h6A, 8'hC3},
        {2'd2, 2'd0, 8'h9F, 8'h26},
        {2'd2, 2'd1, 8'hFF, 8'h10},
        {2'd3, 2'd0, 8'hC9, 8'h55},
        {2'd2, 2'd2, 8'hE7, 8'h5A},
        {2'd1, 2'd3, 8'h2D, 8'hD2}
    };

    function automatic int per_byte(input logic [1:0] d);
        return (d == 2'd1) ? 4 : (d == 2'd2) ? 2 : 8;
    endfunction

    function automatic int hold_of(input logic [1:0] s);
        return (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 1;
    endfunction

    // Expected colour from R1..R4 (identity palette, modulo 8)
    function automatic logic [2:0] model(input logic [1:0] d, input logic [7:0] b, input int k);
        logic [3:0] c;
        c = '0;
        if (d == 2'd1) begin
            c = {2'b00, b[7-k], b[3-k]};
        end else if (d == 2'd2) begin
            for (int j = 0; j < 4; j++) c[3-j] = b[7 - k - 2*j];
        end else begin
            c = {3'b000, b[7-k]};
        end
        return c[2:0];
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {blue_o, green_o, red_o};
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: rgb(bgr)=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Expects to be called right after a negedge
    task automatic run_window(input logic [1:0] d, input logic [1:0] s,
                              input logic [7:0] b0, input logic [7:0] b1, input string req);
        int ppb, h, total;
        ppb = per_byte(d);
        h = hold_of(s);
        total = 2 * ppb * h;
        depth_sel = d;
        scale_sel = s;
        for (int t = 0; t < total; t++) begin
            logic [7:0] b;
            b = (t < ppb * h) ? b0 : b1;
            pix_active = 1'b1;
            // R6: the real byte only on reload clocks, its inverse elsewhere
            byte_in = (t % (ppb * h) == 0) ? b : ~b;
            @(posedge clk);
            @(negedge clk);
            check(req, model(d, b, (t / h) % ppb));
        end
        pix_active = 1'b0;
        byte_in = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        check("R8", 3'b000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        // R9: black during reset
        repeat (3) @(negedge clk);
        pix_active = 1'b1;
        byte_in = 8'hFF;
        @(negedge clk);
        check("R9", 3'b000);
        pix_active = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 3'b000);

        // Vector table covering R1..R7
        foreach (VEC[i]) begin
            string req;
            case (VEC[i][19:18])
                2'd1: req = "R2";
                2'd2: req = "R3";
                2'd3: req = "R4";
                default: req = (VEC[i][17:16] != 2'd0) ? "R5" : "R1";
            endcase
            run_window(VEC[i][19:18], VEC[i][17:16], VEC[i][15:8], VEC[i][7:0], req);
            @(negedge clk);
        end

        // R7: single bits land on red, green, blue (4 bpp: pixel0 uses bits 5,3,1)
        depth_sel = 2'd2; scale_sel = 2'd0;
        pix_active = 1'b1;
        byte_in = 8'b0000_0010;  // pixel0 colour 1 -> red
        @(posedge clk); @(negedge clk);
        check("R7", 3'b001);
        byte_in = 8'hFF;         // ignored, pixel1 from 0x02 bits 6,4,2,0 -> 0
        @(posedge clk); @(negedge clk);
        check("R7", 3'b000);
        byte_in = 8'b0000_1000;  // reload: pixel0 colour 2 -> green
        @(posedge clk); @(negedge clk);
        check("R7", 3'b010);
        byte_in = 8'h00;
        @(posedge clk); @(negedge clk);
        check("R7", 3'b000);
        byte_in = 8'b0010_0000;  // reload: pixel0 colour 4 -> blue
        @(posedge clk); @(negedge clk);
        check("R7", 3'b100);
        pix_active = 1'b0;
        @(posedge clk); @(negedge clk);

        // R8: blank line part way through a byte, then restart at pixel 0
        depth_sel = 2'd0; scale_sel = 2'd0;
        pix_active = 1'b1;
        byte_in = 8'hAA;
        for (int t = 0; t < 3; t++) begin
            @(posedge clk); @(negedge clk);
            check("R1", model(2'd0, 8'hAA, t));
            byte_in = 8'h00;
        end
        blank_line = 1'b1;
        byte_in = 8'hFF;
        @(posedge clk); @(negedge clk);
        check("R8", 3'b000);
        @(posedge clk); @(negedge clk);
        check("R8", 3'b000);
        blank_line = 1'b0;
        byte_in = 8'h5F;
        for (int t = 0; t < 8; t++) begin
            @(posedge clk); @(negedge clk);
            check("R8", model(2'd0, 8'h5F, t));
            byte_in = 8'hA0;
        end
        pix_active = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8", 3'b000);

        // R9: reset in the middle of a window clears output
        pix_active = 1'b1;
        byte_in = 8'hFF;
        @(posedge clk); @(negedge clk);
        check("R9", 3'b001);
        rst_n = 1'b0;
        #1;
        check("R9", 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        pix_active = 1'b0;
        @(posedge clk); @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule